// File: doc/BRIEF.md
# Command Ring Buffer Engine

This block is the controller-side engine that drains a circular queue of 32-bit codec command words. Software keeps the queue in memory, advances a write pointer, then stores each new command at the slot that pointer now names. The engine holds the matching hardware read pointer. While it is running, it fetches each pending entry through a simple word-addressed memory read port and offers the word to the codec link on a valid/ready output.

Software reaches the engine through four 16-bit registers, selected by a 2-bit address: 0 holds the write pointer, 1 holds the read pointer and its reset flag, 2 holds the run control and 3 holds the size code. The read pointer is cleared through a two-step handshake. Reads of either pointer register return all ones while the block is powered down. A full flag marks the state in which one more command would overrun the slot the engine has yet to read.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, register 0 (write pointer) and register 1 (read pointer) read 0x0000, register 2 (control) reads 0x0000, register 3 (size) reads 0x0002, cmdValid is low and queueFull is low.
- R2: The pending entries are those after the read pointer up to and including the write pointer, modulo 256. The engine delivers them in slot order and wraps from slot 255 to slot 0. Once they are drained, the read pointer equals the write pointer.
- R3: Under backpressure, cmdValid and cmdData hold steady until cmdReady is high. The read pointer advances by one only on an accepted word, so no command is lost or repeated.
- R4: queueFull is high exactly when (write pointer + 1) mod 256 equals the read pointer.
- R5: A write to register 1 with bit 15 set clears the read pointer and starts a pointer reset, and the register then reads 0x8000. A later write with bit 15 clear ends the reset, and the register then reads 0x0000.
- R6: While a pointer reset is in progress, no memory read is issued and cmdValid stays low.
- R7: Fetching happens only while control bit 0 (run) is set. When run is cleared, a word already in flight is still delivered and then the engine stops. Control bit 0 reads 1 until the engine has stopped, then reads 0.
- R8: While powerDown is high, reads of registers 0 and 1 return 0xFFFF. Register 2 reads as normal.
- R9: The size register stores a 2-bit code and reads it back. Code 2 selects the 256-entry queue. With any other code, no fetch is issued.
- R10: The upper 4 bits of each command word, which carry the codec address, appear unchanged on cmdData[31:28].
- R11: Only one fetch is in flight at a time. memRdEn is never high in two consecutive cycles, and a fetched word appears on cmdValid two cycles after its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| powerDown | input | 1 | Powered-down state; pointer registers read all ones |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 write pointer, 1 read pointer, 2 control, 3 size |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Combinational readback of the register that regAddr selects |
| memRdEn | output | 1 | Queue memory read strobe |
| memAddr | output | 8 | Queue slot to read |
| memRdData | input | 32 | Queue word, returned one cycle after memRdEn |
| cmdValid | output | 1 | A command word is offered |
| cmdReady | input | 1 | Downstream accepts the offered word |
| cmdData | output | 32 | Command word; bits 31:28 carry the codec address |
| queueFull | output | 1 | The write pointer sits one slot behind the read pointer |

## Verification
If the read pointer drifts from its correct value, the port shows it straight away: memAddr names the wrong slot at the next fetch, and the delivered word sequence then repeats or skips an entry. The bench catches this when it compares every received word with its expected index. A wrong reset flag or a wrong run flag shows on the next register read. It also shows as a fetch issued, or held back, within one to two cycles of the flag changing. Because every slot is written with a word derived from a running sequence number, a single lost or duplicated handshake moves every later comparison, including those after the pointer wraps.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SHOW = 2'd2
  } engState_t;

  typedef struct packed {
    logic wpWrite;
    logic sizeWrite;
    logic ptrReset;
    logic advance;
    logic load;
  } engStrobe_t;

  localparam logic [1:0] REG_WP   = 2'd0;
  localparam logic [1:0] REG_RP   = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_SIZE = 2'd3;
endpackage

// File: rtl/cre_control.sv
module cre_control
  import cre_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       wrRstBit,
  input  logic       wrRunBit,
  input  logic       ringEmpty,
  input  logic       sizeOk,
  input  logic       cmdReady,
  output engStrobe_t strobe,
  output logic       memRdEn,
  output logic       cmdValid,
  output logic       runShown,
  output logic       rstPending
);
  engState_t state, stateNext;
  logic      runReq;
  logic      canFetch;

  assign canFetch = runReq && !rstPending && sizeOk && !ringEmpty;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    memRdEn        = 1'b0;
    strobe.wpWrite   = regWrEn && (regAddr == REG_WP);
    strobe.sizeWrite = regWrEn && (regAddr == REG_SIZE);
    strobe.ptrReset  = regWrEn && (regAddr == REG_RP) && wrRstBit;
    unique case (state)
      ST_IDLE: if (canFetch) begin
        memRdEn   = 1'b1;
        stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.load = 1'b1;
        stateNext   = ST_SHOW;
      end
      ST_SHOW: if (cmdReady) begin
        strobe.advance = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      runReq     <= 1'b0;
      rstPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (regWrEn && regAddr == REG_CTRL) runReq <= wrRunBit;
      if (regWrEn && regAddr == REG_RP) rstPending <= wrRstBit;
    end
  end

  assign cmdValid = (state == ST_SHOW);
  assign runShown = runReq || (state != ST_IDLE);
endmodule

// File: rtl/cre_datapath.sv
module cre_datapath
  import cre_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int WORD_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [1:0]        wrSize,
  input  logic [1:0]        regAddr,
  input  logic              powerDown,
  input  logic              runShown,
  input  logic              rstShown,
  input  logic [WORD_W-1:0] memRdData,
  output logic [PTR_W-1:0]  memAddr,
  output logic [WORD_W-1:0] cmdData,
  output logic [REG_W-1:0]  regRdData,
  output logic              ringEmpty,
  output logic              sizeOk,
  output logic              queueFull
);
  localparam logic [1:0] SIZE_CODE = (PTR_W == 8) ? 2'd2 : ((PTR_W == 4) ? 2'd1 : 2'd0);
  localparam int         PAD_W     = REG_W - PTR_W;

  logic [PTR_W-1:0]  wrIdx, rdIdx;
  logic [1:0]        sizeCode;
  logic [WORD_W-1:0] outWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      rdIdx    <= '0;
      sizeCode <= SIZE_CODE;
      outWord  <= '0;
    end else begin
      if (strobe.wpWrite)   wrIdx    <= wrPtr;
      if (strobe.sizeWrite) sizeCode <= wrSize;
      if (strobe.ptrReset)      rdIdx <= '0;
      else if (strobe.advance)  rdIdx <= rdIdx + 1'b1;
      if (strobe.load) outWord <= memRdData;
    end
  end

  assign memAddr   = rdIdx + 1'b1;
  assign cmdData   = outWord;
  assign ringEmpty = (rdIdx == wrIdx);
  assign sizeOk    = (sizeCode == SIZE_CODE);
  assign queueFull = ((wrIdx + 1'b1) == rdIdx);

  always_comb begin
    unique case (regAddr)
      REG_WP:   regRdData = powerDown ? '1 : {{PAD_W{1'b0}}, wrIdx};
      REG_RP:   regRdData = powerDown ? '1 : {rstShown, {(PAD_W-1){1'b0}}, rdIdx};
      REG_CTRL: regRdData = {{(REG_W-1){1'b0}}, runShown};
      default:  regRdData = {{(REG_W-2){1'b0}}, sizeCode};
    endcase
  end
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cre_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int WORD_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDown,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memRdEn,
  output logic [PTR_W-1:0]  memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [WORD_W-1:0] cmdData,
  output logic              queueFull
);
  engStrobe_t strobe;
  logic       ringEmpty, sizeOk, runShown, rstPending;

  cre_control ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrRstBit(regWrData[REG_W-1]), .wrRunBit(regWrData[0]),
    .ringEmpty(ringEmpty), .sizeOk(sizeOk), .cmdReady(cmdReady),
    .strobe(strobe), .memRdEn(memRdEn), .cmdValid(cmdValid),
    .runShown(runShown), .rstPending(rstPending)
  );

  cre_datapath #(.PTR_W(PTR_W), .WORD_W(WORD_W), .REG_W(REG_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrPtr(regWrData[PTR_W-1:0]), .wrSize(regWrData[1:0]),
    .regAddr(regAddr), .powerDown(powerDown), .runShown(runShown),
    .rstShown(rstPending), .memRdData(memRdData), .memAddr(memAddr),
    .cmdData(cmdData), .regRdData(regRdData), .ringEmpty(ringEmpty),
    .sizeOk(sizeOk), .queueFull(queueFull)
  );
endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [WORD_W-1:0] cmdData,
  input logic              rstPending
);
  a_r3_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));

  a_r11_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  a_r11_fetch_to_offer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(memRdEn, 2));

  a_r6_no_fetch_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstPending |-> !memRdEn);
endmodule

bind cmd_ring_engine cre_checker #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdData(cmdData), .rstPending(rstPending)
);

// File: tb/cmd_ring_engine_test.sv
`timescale 1ns/1ps
module cmd_ring_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerDown = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        memRdEn;
  logic [7:0]  memAddr;
  logic [31:0] memRdData = 32'h0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic        queueFull;

  cmd_ring_engine uut (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .queueFull(queueFull)
  );

  always #2 clk = ~clk;

  logic [31:0] mem [256];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  int nChecks = 0;
  int nFail = 0;
  int recvCount = 0;
  int expCount = 0;
  int fetchCount = 0;
  int readyMode = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] recvBuf [1024];
  logic [31:0] expBuf [1024];
  logic [7:0]  swWp = 8'd0;

  always @(posedge clk) begin
    if (rstN && cmdValid && cmdReady) begin
      recvBuf[recvCount] = cmdData;
      recvCount++;
    end
    if (rstN && memRdEn) fetchCount++;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: cmdReady = 1'b1;
      1: cmdReady = lfsr[0] & lfsr[3];
      default: cmdReady = 1'b0;
    endcase
  end

  function automatic logic [31:0] cmdWord(int s);
    logic [31:0] w;
    w = (32'(s) * 32'h9E3779B1) ^ 32'h00A55A00;
    w[31:28] = 4'(s % 16) ^ 4'((s / 16) % 16);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic stage(input int n);
    for (int j = 0; j < n; j++) begin
      swWp = swWp + 8'd1;
      mem[swWp] = cmdWord(expCount);
      expBuf[expCount] = cmdWord(expCount);
      expCount++;
    end
  endtask

  task automatic push(input int n);
    stage(n);
    wrReg(2'd0, {8'h00, swWp});
  endtask

  task automatic drain(input string tag);
    logic [15:0] v;
    int t;
    t = 0;
    do begin
      rdReg(2'd1, v);
      t++;
    end while ((v[7:0] != swWp || cmdValid) && t < 20000);
    chk(tag, {24'h0, v[7:0]}, {24'h0, swWp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int snap;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 | 32'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(2'd0, v); chk("R1 wp", {16'h0, v}, 32'h0);
    rdReg(2'd1, v); chk("R1 rp", {16'h0, v}, 32'h0);
    rdReg(2'd2, v); chk("R1 ctrl", {16'h0, v}, 32'h0);
    rdReg(2'd3, v); chk("R1 size", {16'h0, v}, 32'h2);
    chk("R1 cmdValid", {31'h0, cmdValid}, 32'h0);
    chk("R1 queueFull", {31'h0, queueFull}, 32'h0);

    // R5 / R6 pointer reset handshake
    wrReg(2'd1, 16'h8000);
    rdReg(2'd1, v); chk("R5 reset ack", {16'h0, v}, 32'h8000);
    readyMode = 0;
    push(3);
    wrReg(2'd2, 16'h0001);
    snap = fetchCount;
    repeat (12) @(negedge clk);
    chk("R6 no fetch", 32'(fetchCount), 32'(snap));
    chk("R6 no valid", {31'h0, cmdValid}, 32'h0);
    wrReg(2'd1, 16'h0000);
    rdReg(2'd1, v); chk("R5 release", {16'h0, v & 16'hFF00}, 32'h0);
    drain("R2 drain first");

    // R2 / R3 chunks with and without backpressure
    push(1); drain("R2 single");
    readyMode = 1;
    push(5); drain("R3 bp small");
    push(100); drain("R3 bp large");

    // R4 full detection with engine stopped
    wrReg(2'd2, 16'h0000);
    repeat (4) @(negedge clk);
    stage(254); wrReg(2'd0, {8'h00, swWp});
    @(negedge clk); chk("R4 not full at 254", {31'h0, queueFull}, 32'h0);
    stage(1); wrReg(2'd0, {8'h00, swWp});
    @(negedge clk); chk("R4 full at 255", {31'h0, queueFull}, 32'h1);
    snap = fetchCount;
    repeat (6) @(negedge clk);
    chk("R7 stopped no fetch", 32'(fetchCount), 32'(snap));
    wrReg(2'd2, 16'h0001);
    drain("R2 wrap drain");
    chk("R4 empty not full", {31'h0, queueFull}, 32'h0);

    // R7 stop while a word is held
    readyMode = 2;
    push(3);
    repeat (10) @(negedge clk);
    chk("R3 held valid", {31'h0, cmdValid}, 32'h1);
    wrReg(2'd2, 16'h0000);
    rdReg(2'd2, v); chk("R7 still busy", {16'h0, v}, 32'h1);
    snap = recvCount;
    readyMode = 0;
    repeat (6) @(negedge clk);
    rdReg(2'd2, v); chk("R7 stopped", {16'h0, v}, 32'h0);
    chk("R7 one delivered", 32'(recvCount), 32'(snap + 1));
    chk("R7 no valid", {31'h0, cmdValid}, 32'h0);
    rdReg(2'd1, v); chk("R7 rp one step", {24'h0, v[7:0]}, {24'h0, swWp - 8'd2});
    wrReg(2'd2, 16'h0001);
    drain("R7 resume drain");

    // R9 size gating
    wrReg(2'd3, 16'h0001);
    rdReg(2'd3, v); chk("R9 size readback", {16'h0, v}, 32'h1);
    snap = fetchCount;
    push(4);
    repeat (12) @(negedge clk);
    chk("R9 no fetch bad size", 32'(fetchCount), 32'(snap));
    wrReg(2'd3, 16'h0002);
    readyMode = 1;
    drain("R9 drain after size");

    // R8 powered down readback
    powerDown = 1'b1;
    rdReg(2'd0, v); chk("R8 wp pd", {16'h0, v}, 32'hFFFF);
    rdReg(2'd1, v); chk("R8 rp pd", {16'h0, v}, 32'hFFFF);
    rdReg(2'd2, v); chk("R8 ctrl pd", {16'h0, v}, 32'h1);
    powerDown = 1'b0;
    rdReg(2'd0, v); chk("R8 wp restored", {16'h0, v}, {24'h0, swWp});

    // R2 / R3 / R10 full stream compare
    repeat (10) @(negedge clk);
    chk("R3 count", 32'(recvCount), 32'(expCount));
    for (int i = 0; i < expCount; i++) begin
      chk($sformatf("R2 word %0d", i), recvBuf[i], expBuf[i]);
      chk($sformatf("R10 codec %0d", i), {28'h0, recvBuf[i][31:28]},
          {28'h0, 4'(i % 16) ^ 4'((i / 16) % 16)});
    end
    chk("R11 fetch count", 32'(fetchCount), 32'(expCount));

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule